// File: doc/BRIEF.md
# Floating-Point Status and Exception Summary Unit

This block holds the 32-bit floating-point status and control word of a processor core and updates it once for every completed floating-point instruction. The execution pipe presents that instruction's event flags: overflow, underflow, divide-by-zero, inexact, a vector of invalid-operation causes, fraction-rounded, fraction-inexact and a 5-bit result class. The unit merges them into the word, keeps a sticky any-exception flag, and recomputes the invalid summary and the enabled-exception summary from the merged bits.

In the same cycle as the update strobe it offers the new top four status bits as a condition-field-1 value, with a write strobe when the instruction has its record bit set. It also raises a one-cycle program-interrupt request when an enabled exception is pending and either of the two machine-state exception-mode bits is set. A separate load strobe overwrites the whole word. This is the move-to-status path, and it is also how the enable bits are set.

Bit positions below are counted from the most significant bit. Position p is bit 31-p of `fpscr_o`.

Top module: `fp_status_unit`

## Requirements
- R1: After reset, `fpscr_o` is zero, and `cr1_we_o` and `irq_o` are low.
- R2: On an update, the overflow, underflow and divide-by-zero conditions each set their status bit when true. These bits are at positions 3, 4 and 5. A true condition also sets the sticky any-exception bit at position 0. A false condition clears its own status bit.
- R3: An update with the inexact condition true sets the inexact bit at position 6 and the any-exception bit. An update with it false leaves the inexact bit unchanged.
- R4: Each set bit k of `inv_i` ORs a one into position 7+k and sets the any-exception bit. No update ever clears an invalid-cause bit.
- R5: After every update, the invalid summary at position 2 equals the OR of the cause bits at positions 7 to 15.
- R6: After every update, the enabled-exception summary at position 1 is the OR of five terms, each a status bit ANDed with its enable. The pairs are: invalid summary with position 24, overflow with 25, underflow with 26, divide-by-zero with 27, and inexact with 28.
- R7: An update copies `fr_i` into position 16 and `fi_i` into position 17. It replaces positions 18 to 22 with `cls_i`, with `cls_i[4]` at position 18. Positions 23 and 29 to 31 keep their value.
- R8: In an update cycle with `rc_i` high, `cr1_we_o` is high and `cr1_o` carries the new positions 0 to 3, with position 0 on `cr1_o[3]`. With `rc_i` low, `cr1_we_o` stays low.
- R9: `irq_o` is high for exactly the update cycle when `exc_mode_i` is nonzero and the new enabled-exception summary is one.
- R10: `load_i` writes `load_val_i` into the word verbatim. It takes priority over `valid_i` in the same cycle, and that cycle raises neither `cr1_we_o` nor `irq_o`.
- R11: With neither `valid_i` nor `load_i` high, the word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction-complete update strobe |
| ovf_i | input | 1 | Overflow condition |
| unf_i | input | 1 | Underflow condition |
| zdiv_i | input | 1 | Divide-by-zero condition |
| inx_i | input | 1 | Inexact condition |
| inv_i | input | 9 | Invalid-operation causes |
| fr_i | input | 1 | Fraction-rounded condition |
| fi_i | input | 1 | Fraction-inexact condition |
| cls_i | input | 5 | Result class |
| rc_i | input | 1 | Record bit |
| exc_mode_i | input | 2 | Machine-state exception-mode bits |
| load_i | input | 1 | Whole-word load strobe |
| load_val_i | input | 32 | Value to load |
| fpscr_o | output | 32 | Status and control word |
| cr1_o | output | 4 | Condition field 1 value |
| cr1_we_o | output | 1 | Condition field 1 write strobe |
| irq_o | output | 1 | Program-interrupt request |

## Verification
The bench builds the block with its default layout: nine invalid causes and a five-bit class field. Every status, enable and summary bit therefore sits at a fixed position that the bench can check as a whole-word value. Loads set individual enable bits, so each of the summary's product terms can be made to raise or withhold the interrupt on its own. Sequences of updates show the difference between bits that clear when their condition is false and bits that are sticky.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
  localparam int REG_W = 32;
  localparam int INV_W = 9;
  localparam int CLS_W = 5;
  localparam int CR_W  = 4;

  // positions counted from the MSB
  localparam int P_FX  = 0;
  localparam int P_FEX = 1;
  localparam int P_VX  = 2;
  localparam int P_OX  = 3;
  localparam int P_UX  = 4;
  localparam int P_ZX  = 5;
  localparam int P_XX  = 6;
  localparam int P_INV = 7;
  localparam int P_FR  = P_INV + INV_W;
  localparam int P_FI  = P_FR + 1;
  localparam int P_CLS = P_FI + 1;
  localparam int P_VE  = 24;
  localparam int P_OE  = 25;
  localparam int P_UE  = 26;
  localparam int P_ZE  = 27;
  localparam int P_XE  = 28;

  // vector indices
  localparam int I_FX   = REG_W - 1 - P_FX;
  localparam int I_FEX  = REG_W - 1 - P_FEX;
  localparam int I_VX   = REG_W - 1 - P_VX;
  localparam int I_OX   = REG_W - 1 - P_OX;
  localparam int I_UX   = REG_W - 1 - P_UX;
  localparam int I_ZX   = REG_W - 1 - P_ZX;
  localparam int I_XX   = REG_W - 1 - P_XX;
  localparam int I_INV0 = REG_W - 1 - P_INV;
  localparam int I_FR   = REG_W - 1 - P_FR;
  localparam int I_FI   = REG_W - 1 - P_FI;
  localparam int I_CLS  = REG_W - 1 - P_CLS;
  localparam int I_VE   = REG_W - 1 - P_VE;
  localparam int I_OE   = REG_W - 1 - P_OE;
  localparam int I_UE   = REG_W - 1 - P_UE;
  localparam int I_ZE   = REG_W - 1 - P_ZE;
  localparam int I_XE   = REG_W - 1 - P_XE;

  typedef struct packed {
    logic             ovf;
    logic             unf;
    logic             zdiv;
    logic             inx;
    logic [INV_W-1:0] inv;
    logic             fr;
    logic             fi;
    logic [CLS_W-1:0] cls;
  } fp_event_t;
endpackage

// File: rtl/fpsu_event_merge.sv
module fpsu_event_merge
  import fpsu_pkg::*;
(
  input  logic [REG_W-1:0] cur_i,
  input  fp_event_t        ev_i,
  output logic [REG_W-1:0] nxt_o
);
  logic any_exc;

  assign any_exc = ev_i.ovf | ev_i.unf | ev_i.zdiv | ev_i.inx | (|ev_i.inv);

  always_comb begin
    nxt_o       = cur_i;
    nxt_o[I_OX] = ev_i.ovf;
    nxt_o[I_UX] = ev_i.unf;
    nxt_o[I_ZX] = ev_i.zdiv;
    if (ev_i.inx) nxt_o[I_XX] = 1'b1;
    for (int k = 0; k < INV_W; k++) begin
      if (ev_i.inv[k]) nxt_o[I_INV0-k] = 1'b1;
    end
    if (any_exc) nxt_o[I_FX] = 1'b1;
    nxt_o[I_FR]            = ev_i.fr;
    nxt_o[I_FI]            = ev_i.fi;
    nxt_o[I_CLS -: CLS_W]  = ev_i.cls;
  end
endmodule

// File: rtl/fpsu_summary.sv
module fpsu_summary
  import fpsu_pkg::*;
(
  input  logic [REG_W-1:0] st_i,
  output logic             vx_o,
  output logic             fex_o
);
  logic [INV_W-1:0] causes;

  for (genvar k = 0; k < INV_W; k++) begin : g_cause
    assign causes[k] = st_i[I_INV0-k];
  end

  assign vx_o  = |causes;
  assign fex_o = (vx_o       & st_i[I_VE]) |
                 (st_i[I_OX] & st_i[I_OE]) |
                 (st_i[I_UX] & st_i[I_UE]) |
                 (st_i[I_ZX] & st_i[I_ZE]) |
                 (st_i[I_XX] & st_i[I_XE]);
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
  import fpsu_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 ovf_i,
  input  logic                 unf_i,
  input  logic                 zdiv_i,
  input  logic                 inx_i,
  input  logic [INV_W-1:0]     inv_i,
  input  logic                 fr_i,
  input  logic                 fi_i,
  input  logic [CLS_W-1:0]     cls_i,
  input  logic                 rc_i,
  input  logic [1:0]           exc_mode_i,
  input  logic                 load_i,
  input  logic [REG_W-1:0]     load_val_i,
  output logic [REG_W-1:0]     fpscr_o,
  output logic [CR_W-1:0]      cr1_o,
  output logic                 cr1_we_o,
  output logic                 irq_o
);
  fp_event_t        ev;
  logic [REG_W-1:0] fpscr_q, merged, upd;
  logic             vx, fex, upd_en;

  assign ev = '{ovf: ovf_i, unf: unf_i, zdiv: zdiv_i, inx: inx_i,
                inv: inv_i, fr: fr_i, fi: fi_i, cls: cls_i};

  fpsu_event_merge u_merge (.cur_i(fpscr_q), .ev_i(ev), .nxt_o(merged));
  fpsu_summary     u_sum   (.st_i(merged), .vx_o(vx), .fex_o(fex));

  always_comb begin
    upd        = merged;
    upd[I_VX]  = vx;
    upd[I_FEX] = fex;
  end

  assign upd_en = valid_i & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fpscr_q <= '0;
    else if (load_i)  fpscr_q <= load_val_i;
    else if (valid_i) fpscr_q <= upd;
  end

  assign fpscr_o  = fpscr_q;
  assign cr1_o    = upd[I_FX -: CR_W];
  assign cr1_we_o = upd_en & rc_i;
  assign irq_o    = upd_en & (|exc_mode_i) & fex;

  a_r2_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en && ovf_i |=> fpscr_q[I_OX] && fpscr_q[I_FX]);
  a_r3_inexact_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en && fpscr_q[I_XX] |=> fpscr_q[I_XX]);
  a_r4_inv_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en |=> ((fpscr_q[I_INV0 -: INV_W] & $past(fpscr_q[I_INV0 -: INV_W]))
                == $past(fpscr_q[I_INV0 -: INV_W])));
  a_r5_vx_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en |=> fpscr_q[I_VX] == (|fpscr_q[I_INV0 -: INV_W]));
  a_r8_cr1_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr1_we_o |-> valid_i && rc_i && !load_i);
  a_r9_irq_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> exc_mode_i != 2'b00 && upd_en);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !load_i |=> $stable(fpscr_q));
endmodule

// File: tb/fp_status_unit_test.sv
module fp_status_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, ovf = 1'b0, unf = 1'b0, zdiv = 1'b0, inx = 1'b0;
  logic [8:0]  inv = '0;
  logic        fr = 1'b0, fi = 1'b0;
  logic [4:0]  cls = '0;
  logic        rc = 1'b0;
  logic [1:0]  mode = '0;
  logic        load = 1'b0;
  logic [31:0] load_val = '0;
  logic [31:0] fpscr;
  logic [3:0]  cr1;
  logic        cr1_we, irq;

  int vectors = 0, miscompares = 0;
  logic       c_irq, c_we;
  logic [3:0] c_cr1;
  bit         done = 0;

  always #10 clk = ~clk;

  fp_status_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ovf_i(ovf), .unf_i(unf),
    .zdiv_i(zdiv), .inx_i(inx), .inv_i(inv), .fr_i(fr), .fi_i(fi), .cls_i(cls),
    .rc_i(rc), .exc_mode_i(mode), .load_i(load), .load_val_i(load_val),
    .fpscr_o(fpscr), .cr1_o(cr1), .cr1_we_o(cr1_we), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the following negedge with the word updated.
  task automatic op(input logic o, u, z, x, input logic [8:0] iv, input logic f_r, f_i,
                    input logic [4:0] c, input logic r, input logic [1:0] m);
    valid = 1'b1; ovf = o; unf = u; zdiv = z; inx = x; inv = iv;
    fr = f_r; fi = f_i; cls = c; rc = r; mode = m;
    #2;
    c_irq = irq; c_we = cr1_we; c_cr1 = cr1;
    @(negedge clk);
    valid = 1'b0; ovf = 1'b0; unf = 1'b0; zdiv = 1'b0; inx = 1'b0; inv = '0;
    fr = 1'b0; fi = 1'b0; cls = '0; rc = 1'b0; mode = '0;
  endtask

  task automatic ld(input logic [31:0] v);
    load = 1'b1; load_val = v;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 word", fpscr, 32'h0);
    chk("R1 we", {31'b0, cr1_we}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_overflow;
    ld(32'h0000_0040);                       // overflow enable, position 25
    chk("R10 load", fpscr, 32'h0000_0040);
    op(1, 0, 0, 0, '0, 0, 0, '0, 1, 2'b00);
    chk("R2 ovf set", fpscr, 32'hD000_0040);
    chk("R6 fex ovf", {31'b0, fpscr[30]}, 32'h1);
    chk("R8 cr1", {28'b0, c_cr1}, 32'hD);
    chk("R8 we", {31'b0, c_we}, 32'h1);
    chk("R9 mode zero no irq", {31'b0, c_irq}, 32'h0);
    op(0, 0, 0, 0, '0, 0, 0, '0, 1, 2'b01);
    chk("R2 ovf cleared", fpscr, 32'h8000_0040);
    chk("R8 cr1 after clear", {28'b0, c_cr1}, 32'h8);
    chk("R9 no enabled exc", {31'b0, c_irq}, 32'h0);
  endtask

  task automatic t_unf_zdiv;
    ld(32'h0000_0020);                       // underflow enable, position 26
    op(0, 1, 1, 0, '0, 0, 0, '0, 0, 2'b01);
    chk("R2 unf zdiv", fpscr, 32'hCC00_0020);
    chk("R9 irq", {31'b0, c_irq}, 32'h1);
    chk("R8 rc low", {31'b0, c_we}, 32'h0);
    op(1, 0, 0, 0, '0, 0, 0, '0, 0, 2'b01);
    chk("R2 unf zdiv cleared", fpscr, 32'h9000_0020);
    chk("R9 disabled ovf", {31'b0, c_irq}, 32'h0);
  endtask

  task automatic t_inexact;
    ld(32'h0000_0000);
    op(0, 0, 0, 1, '0, 0, 0, '0, 0, 2'b00);
    chk("R3 inexact set", fpscr, 32'h8200_0000);
    op(0, 0, 0, 0, '0, 0, 0, '0, 0, 2'b00);
    chk("R3 inexact kept", fpscr, 32'h8200_0000);
  endtask

  task automatic t_invalid;
    ld(32'h0000_0080);                       // invalid enable, position 24
    op(0, 0, 0, 0, 9'b0_0000_1000, 0, 0, '0, 1, 2'b10);
    chk("R4 R5 invalid", fpscr, 32'hE020_0080);
    chk("R9 irq invalid", {31'b0, c_irq}, 32'h1);
    chk("R8 cr1 invalid", {28'b0, c_cr1}, 32'hE);
    op(0, 0, 0, 0, 9'b1_0000_0000, 0, 0, '0, 0, 2'b10);
    chk("R4 causes sticky", fpscr, 32'hE021_0080);
    chk("R9 irq persists", {31'b0, c_irq}, 32'h1);
    ld(32'h2000_0000);                       // stale summary, no causes
    op(0, 0, 0, 0, '0, 0, 0, '0, 0, 2'b00);
    chk("R5 vx recomputed", fpscr, 32'h0000_0000);
  endtask

  task automatic t_fields;
    ld(32'h0000_0107);                       // positions 23, 29, 30, 31
    op(0, 0, 0, 0, '0, 1, 0, 5'b10110, 0, 2'b00);
    chk("R7 fr cls", fpscr, 32'h0000_AD07);
    op(0, 0, 0, 0, '0, 0, 1, 5'b00001, 0, 2'b00);
    chk("R7 fi cls", fpscr, 32'h0000_4307);
    repeat (3) @(negedge clk);
    chk("R11 hold", fpscr, 32'h0000_4307);
  endtask

  task automatic t_load_priority;
    load = 1'b1; load_val = 32'h0000_0005;
    valid = 1'b1; ovf = 1'b1; rc = 1'b1; mode = 2'b11;
    #2;
    c_irq = irq; c_we = cr1_we;
    @(negedge clk);
    load = 1'b0; valid = 1'b0; ovf = 1'b0; rc = 1'b0; mode = '0;
    chk("R10 load wins", fpscr, 32'h0000_0005);
    chk("R10 no we", {31'b0, c_we}, 32'h0);
    chk("R10 no irq", {31'b0, c_irq}, 32'h0);
  endtask

  initial begin
    #100_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_overflow();
    t_unf_zdiv();
    t_inexact();
    t_invalid();
    t_fields();
    t_load_priority();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule